// File: doc/BRIEF.md
# Two-Wire Bus Event Monitor

This block listens to the clock and data lines of a two-wire serial bus (I2C) without ever driving them. Both lines are sampled by a fast system clock through synchronisers. The block turns what it sees into a stream of typed event records. Each record is a one-cycle valid pulse that carries a 4-bit event code and a byte-wide value. It is meant to sit beside a bus as a protocol trace source that feeds a capture buffer or a checker.

The block follows each transfer. It sees the start condition, collects the address byte and splits off its direction bit, and then reads the acknowledge bit. After that it collects data bytes until a stop condition or a new start arrives. A start that comes while a transfer is still open, with no stop since the previous start, is reported with a separate code. Data bytes carry the direction taken from the most recent address byte.

Top module: `twi_bus_watcher`

## Requirements
- R1: After the asynchronous active-low reset, evt_valid is low and the block is idle. The repeated-start flag is clear and the transfer direction is unknown.
- R2: While idle, SDA falling from 1 to 0 while SCL is 1 is a start condition. It produces an event with code 0 and value 0.
- R3: After a start, the block collects 8 bits on SCL rising edges, most significant bit first. If bit 0 of the byte is 0, the event code is 3 (address, write). If bit 0 is 1, the event code is 4 (address, read). evt_data holds the upper seven bits, right-aligned, so evt_data[7] is 0.
- R4: The SCL rising edge after the eighth bit samples the acknowledge bit. SDA = 0 gives code 7 (ACK) and SDA = 1 gives code 8 (NACK). Both carry value 0.
- R5: After an acknowledge, each further 8 bits form a data byte reported with all 8 bits. The code is 5 if the latched direction is write and 6 if it is read. Any number of data bytes may follow one another.
- R6: In the data phase, a start with no stop since the previous start gives code 1 (repeated start) and restarts address collection. A stop (SDA rising with SCL at 1) gives code 2 with value 0 and returns the block to idle. A stop also clears the repeated-start flag and the direction, so the next start reports code 0.
- R7: While the address bits are being collected, or while the acknowledge bit is awaited, SDA changes with SCL at 1 produce no event. The bit value taken at the SCL rising edge stands.
- R8: While idle, SCL edges and SDA rising edges with SCL at 1 produce no event.
- R9: An event's evt_valid pulse is high for exactly one clock cycle. It appears SYNC_STAGES+1 clock edges after the line change that causes it, which is 3 edges at the default.
- R10: During the first SYNC_STAGES+1 clock edges after reset, the synchronised line levels only initialise the edge detector. Line levels held through reset produce no event, even when they differ from an idle bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line, observed only |
| sda_in | input | 1 | Bus data line, observed only |
| evt_valid | output | 1 | One-cycle pulse marking a new event record |
| evt_type | output | 4 | Event code (0 start, 1 repeated start, 2 stop, 3 address write, 4 address read, 5 data write, 6 data read, 7 ACK, 8 NACK) |
| evt_data | output | DATA_W | Byte value for address and data events, zero otherwise |

## Verification
Every event is due exactly three clock edges after the line change that causes it. Two of those edges are the synchroniser flops and one is the registered record. The bench therefore changes the lines on a falling clock edge and samples the outputs on the third falling edge after that. At that point the expected pulse must be present, or absent when no event is expected. When a pulse is expected, the bench samples one more falling edge and checks that evt_valid has dropped. This confirms that the pulse lasts a single cycle. The reset test holds the bus in a non-idle state through the warm-up window and checks every cycle of that window.

// File: rtl/twiw_pkg.sv
package twiw_pkg;
   typedef enum logic [3:0] {
      EV_START   = 4'd0,
      EV_RSTART  = 4'd1,
      EV_STOP    = 4'd2,
      EV_ADDR_WR = 4'd3,
      EV_ADDR_RD = 4'd4,
      EV_DATA_WR = 4'd5,
      EV_DATA_RD = 4'd6,
      EV_ACK     = 4'd7,
      EV_NACK    = 4'd8
   } evt_kind_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ADDR,
      PH_ACK,
      PH_DATA
   } phase_t;

   typedef enum logic [1:0] {
      DIR_UNK,
      DIR_WR,
      DIR_RD
   } dir_t;
endpackage

// File: rtl/twiw_sync.sv
module twiw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("twiw_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/twiw_cond.sv
module twiw_cond #(
   parameter int WARM = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic start_cond,
   output logic stop_cond
);
   localparam int CW = $clog2(WARM + 1);

   logic [CW-1:0] warm_q;
   logic          scl_p, sda_p;
   logic          armed;

   assign armed = (warm_q == CW'(WARM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warm_q <= '0;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         if (!armed) warm_q <= warm_q + 1'b1;
         scl_p <= scl;
         sda_p <= sda;
      end
   end

   assign scl_rise   = armed & ~scl_p & scl;
   assign start_cond = armed & scl & sda_p & ~sda;
   assign stop_cond  = armed & scl & ~sda_p & sda;

   // R10
   warm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == '0) |=> !(scl_rise || start_cond || stop_cond));
endmodule

// File: rtl/twiw_decode.sv
module twiw_decode
   import twiw_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              start_cond,
   input  logic              stop_cond,
   input  logic              sda,
   output logic              evt_valid,
   output logic [3:0]        evt_type,
   output logic [DATA_W-1:0] evt_data
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   phase_t            phase_q, phase_d;
   dir_t              dir_q, dir_d;
   logic              rep_q, rep_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [DATA_W-1:0] shift_q, shift_d, byte_w;
   logic              v_d;
   logic [3:0]        t_d;
   logic [DATA_W-1:0] data_d;
   logic              do_start, do_stop, do_bit, do_ack;

   assign byte_w   = {shift_q[DATA_W-2:0], sda};
   assign do_bit   = scl_rise && (phase_q == PH_ADDR || phase_q == PH_DATA);
   assign do_ack   = scl_rise && (phase_q == PH_ACK);
   assign do_start = start_cond && !scl_rise &&
                     (phase_q == PH_IDLE || phase_q == PH_DATA);
   assign do_stop  = stop_cond && !scl_rise && (phase_q == PH_DATA);

   always_comb begin
      phase_d = phase_q;
      dir_d   = dir_q;
      rep_d   = rep_q;
      cnt_d   = cnt_q;
      shift_d = shift_q;
      v_d     = 1'b0;
      t_d     = evt_type;
      data_d  = evt_data;
      if (do_start) begin
         v_d     = 1'b1;
         t_d     = rep_q ? EV_RSTART : EV_START;
         data_d  = '0;
         rep_d   = 1'b1;
         cnt_d   = '0;
         shift_d = '0;
         phase_d = PH_ADDR;
      end else if (do_stop) begin
         v_d     = 1'b1;
         t_d     = EV_STOP;
         data_d  = '0;
         rep_d   = 1'b0;
         dir_d   = DIR_UNK;
         phase_d = PH_IDLE;
      end else if (do_ack) begin
         v_d     = 1'b1;
         t_d     = sda ? EV_NACK : EV_ACK;
         data_d  = '0;
         phase_d = PH_DATA;
      end else if (do_bit) begin
         if (cnt_q == LAST_BIT) begin
            v_d     = 1'b1;
            cnt_d   = '0;
            shift_d = '0;
            phase_d = PH_ACK;
            if (phase_q == PH_ADDR) begin
               t_d    = byte_w[0] ? EV_ADDR_RD : EV_ADDR_WR;
               dir_d  = byte_w[0] ? DIR_RD : DIR_WR;
               data_d = {1'b0, byte_w[DATA_W-1:1]};
            end else begin
               t_d    = (dir_q == DIR_RD) ? EV_DATA_RD : EV_DATA_WR;
               data_d = byte_w;
            end
         end else begin
            cnt_d   = cnt_q + 1'b1;
            shift_d = byte_w;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         dir_q     <= DIR_UNK;
         rep_q     <= 1'b0;
         cnt_q     <= '0;
         shift_q   <= '0;
         evt_valid <= 1'b0;
         evt_type  <= '0;
         evt_data  <= '0;
      end else begin
         phase_q   <= phase_d;
         dir_q     <= dir_d;
         rep_q     <= rep_d;
         cnt_q     <= cnt_d;
         shift_q   <= shift_d;
         evt_valid <= v_d;
         evt_type  <= t_d;
         evt_data  <= data_d;
      end
   end

   // R2
   nonbyte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_type inside {EV_START, EV_RSTART, EV_STOP, EV_ACK, EV_NACK}))
         |-> (evt_data == '0));
   // R3
   addr_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_type == EV_ADDR_WR || evt_type == EV_ADDR_RD))
         |-> !evt_data[DATA_W-1]);
   // R4
   ack_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_type == EV_ACK || evt_type == EV_NACK))
         |-> ($past(phase_q) == PH_ACK));
   // R5
   data_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_type == EV_DATA_RD) |-> (dir_q == DIR_RD));
   // R6
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_type == EV_STOP)
         |-> (phase_q == PH_IDLE && dir_q == DIR_UNK && !rep_q));
endmodule

// File: rtl/twi_bus_watcher.sv
module twi_bus_watcher #(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              evt_valid,
   output logic [3:0]        evt_type,
   output logic [DATA_W-1:0] evt_data
);
   localparam int LINES = 2;
   localparam int WARM  = SYNC_STAGES + 1;

   logic [LINES-1:0] raw_w, syn_w;
   logic             scl_rise, start_cond, stop_cond;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("twi_bus_watcher: DATA_W must be at least 2");
      end
   endgenerate

   assign raw_w = {scl_in, sda_in};

   generate
      for (genvar gi = 0; gi < LINES; gi++) begin : g_line
         twiw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (raw_w[gi]),
            .q     (syn_w[gi])
         );
      end
   endgenerate

   twiw_cond #(.WARM(WARM)) u_cond (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl        (syn_w[1]),
      .sda        (syn_w[0]),
      .scl_rise   (scl_rise),
      .start_cond (start_cond),
      .stop_cond  (stop_cond)
   );

   twiw_decode #(.DATA_W(DATA_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .start_cond (start_cond),
      .stop_cond  (stop_cond),
      .sda        (syn_w[0]),
      .evt_valid  (evt_valid),
      .evt_type   (evt_type),
      .evt_data   (evt_data)
   );
endmodule

// File: tb/sim_twi_bus_watcher.sv
`timescale 1ns/1ps
module sim_twi_bus_watcher;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda = 1'b1;
   logic       evt_valid;
   logic [3:0] evt_type;
   logic [7:0] evt_data;
   int         n_chk = 0;
   int         n_fail = 0;

   always #10 clk = ~clk;

   twi_bus_watcher u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl),
      .sda_in    (sda),
      .evt_valid (evt_valid),
      .evt_type  (evt_type),
      .evt_data  (evt_data)
   );

   // entry = {op[1:0] (0 start, 1 byte, 2 stop), byte, ack bit, expected code, expected value}
   localparam int NOPS = 14;
   localparam logic [22:0] OPS [NOPS] = '{
      {2'd0, 8'h00, 1'b0, 4'd0, 8'h00},
      {2'd1, 8'hA0, 1'b0, 4'd3, 8'h50},
      {2'd1, 8'h3C, 1'b0, 4'd5, 8'h3C},
      {2'd1, 8'h81, 1'b1, 4'd5, 8'h81},
      {2'd0, 8'h00, 1'b0, 4'd1, 8'h00},
      {2'd1, 8'hA1, 1'b0, 4'd4, 8'h50},
      {2'd1, 8'hC5, 1'b1, 4'd6, 8'hC5},
      {2'd2, 8'h00, 1'b0, 4'd2, 8'h00},
      {2'd0, 8'h00, 1'b0, 4'd0, 8'h00},
      {2'd1, 8'hFF, 1'b0, 4'd4, 8'h7F},
      {2'd1, 8'h00, 1'b1, 4'd6, 8'h00},
      {2'd0, 8'h00, 1'b0, 4'd1, 8'h00},
      {2'd1, 8'h00, 1'b0, 4'd3, 8'h00},
      {2'd2, 8'h00, 1'b0, 4'd2, 8'h00}
   };

   task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive lines at a falling edge, sample on the third falling edge after
   task automatic step(input logic c, input logic d, input logic v,
                       input logic [3:0] t, input logic [7:0] dv, input string req);
      scl = c;
      sda = d;
      repeat (3) @(negedge clk);
      if (v) begin
         chk(req, {evt_valid, evt_type, evt_data}, {1'b1, t, dv});
         @(negedge clk);
         chk("R9 pulse width", {evt_valid, 12'h000}, 13'h0000);
      end else begin
         chk(req, {evt_valid, 12'h000}, 13'h0000);
      end
   endtask

   task automatic do_start(input logic [3:0] et, input string req);
      step(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, req);
      step(1'b1, 1'b1, 1'b0, 4'd0, 8'h00, req);
      step(1'b1, 1'b0, 1'b1, et, 8'h00, req);
   endtask

   task automatic do_stop();
      step(1'b0, 1'b0, 1'b0, 4'd0, 8'h00, "R6");
      step(1'b1, 1'b0, 1'b0, 4'd0, 8'h00, "R6");
      step(1'b1, 1'b1, 1'b1, 4'd2, 8'h00, "R6 stop");
   endtask

   task automatic do_byte(input logic [7:0] val, input logic ack, input logic [3:0] et,
                          input logic [7:0] ed, input int glitch_bit, input logic glitch_ack,
                          input string req);
      for (int i = 7; i >= 0; i--) begin
         step(1'b0, val[i], 1'b0, 4'd0, 8'h00, req);
         step(1'b1, val[i], (i == 0), et, ed, req);
         if (i == glitch_bit) begin
            step(1'b1, ~val[i], 1'b0, 4'd0, 8'h00, "R7 bit glitch");
            step(1'b1, val[i], 1'b0, 4'd0, 8'h00, "R7 bit glitch");
         end
      end
      if (glitch_ack) begin
         step(1'b1, ~val[0], 1'b0, 4'd0, 8'h00, "R7 ack-wait glitch");
         step(1'b1, val[0], 1'b0, 4'd0, 8'h00, "R7 ack-wait glitch");
      end
      step(1'b0, ack, 1'b0, 4'd0, 8'h00, "R4");
      step(1'b1, ack, 1'b1, ack ? 4'd8 : 4'd7, 8'h00, "R4 acknowledge");
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R10: non-idle levels (SDA low, SCL high) held through reset
      scl = 1'b1;
      sda = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset valid", {evt_valid, evt_type, evt_data}, 13'h0000);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk("R10 warm-up quiet", {evt_valid, 12'h000}, 13'h0000);
      end
      // R8: idle ignores SDA rising with SCL high and SCL toggles
      step(1'b1, 1'b1, 1'b0, 4'd0, 8'h00, "R8 idle stop");
      step(1'b0, 1'b1, 1'b0, 4'd0, 8'h00, "R8 idle scl fall");
      step(1'b1, 1'b1, 1'b0, 4'd0, 8'h00, "R8 idle scl rise");
      step(1'b1, 1'b1, 1'b0, 4'd0, 8'h00, "R1 idle hold");

      for (int n = 0; n < NOPS; n++) begin
         case (OPS[n][22:21])
            2'd0: do_start(OPS[n][11:8], "R2 R6 start");
            2'd1: do_byte(OPS[n][20:13], OPS[n][12], OPS[n][11:8], OPS[n][7:0],
                          -1, 1'b0, "R3 R5 byte");
            default: do_stop();
         endcase
      end

      // R7: glitches during address bits and the acknowledge wait
      do_start(4'd0, "R6 flag cleared by stop");
      do_byte(8'h5A, 1'b0, 4'd3, 8'h2D, 3, 1'b1, "R7 address after glitches");
      do_byte(8'h96, 1'b1, 4'd5, 8'h96, -1, 1'b0, "R5 data write");
      do_stop();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule